// File: doc/BRIEF.md
# Bank Class Identification Responder

This block sits on an expansion card's static-memory bus and lets start-up configuration software find out what kind of card occupies a bank. A read of the bank's final word returns an 8-bit class code on the low data byte. Every other address, and every cycle that is not a selected read, leaves the bus alone. The width strap picks a 16-bit or a 32-bit bank, and it sets which low address bits are ignored and which byte lanes the block drives.

The bus holds its last driven value when nobody drives it, and the block carries a per-lane model of that hold. The value 0xFF is never used as a class code. Software can therefore write 0xFF, read the identification word, and treat 0xFF coming back as an empty bank. A parameter builds the block without a responder, which models an unpopulated bank. Another parameter narrows address decoding to the low address bits only.

Top module: `cid_responder`

## Requirements
- R1: In 32-bit mode (bus_wide=1) a selected read hits when addr[25:2] are all ones; addr[1:0] have no effect.
- R2: In 16-bit mode (bus_wide=0) a selected read hits when addr[25:1] are all ones; addr[0] has no effect, and addr[1]=0 gives no hit.
- R3: A read at any other address drives no byte lane (rsp_lane_en all zero).
- R4: Lanes are driven only while cs_n=0 and oe_n=0 together; if either is high, rsp_lane_en is zero.
- R5: On a hit, rsp_data[7:0] equals CLASS_CODE and rsp_data[31:8] are zero. rsp_lane_en is 4'b1111 in 32-bit mode and 4'b0011 (lanes 0 and 1, bits 15:0) in 16-bit mode.
- R6: The responder never drives the reserved code 0xFF on bits 7:0.
- R7: bus_level shows each lane's driver while one is active, with the responder taking priority over the host. A host write drives lanes 0,1 in 16-bit mode and all four in 32-bit mode. A lane nobody drives keeps the value it held at the last clock edge when it was driven. After reset every lane reads zero.
- R8: With PRESENT=0, a host write of 0x000000FF followed by a read of the identification word drives no lane, and bus_level reads 0x000000FF.
- R9: With DEC_BITS=12, only addr[11:2] (wide) are compared. addr=0x0000FFC hits, even though the full-decode build does not hit there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the bus-hold model |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Bank chip select, active low |
| oe_n | input | 1 | Output enable (read strobe), active low |
| addr | input | 26 | Byte address within the bank |
| bus_wide | input | 1 | Width strap: 1 = 32-bit bank, 0 = 16-bit bank |
| host_drive | input | 1 | Host is driving the data bus (write) |
| host_data | input | 32 | Value the host drives |
| rsp_lane_en | output | 4 | Per-byte-lane drive enable of the responder (zero = high impedance) |
| rsp_data | output | 32 | Value the responder drives on enabled lanes |
| bus_level | output | 32 | Resolved bus value including the hold behaviour |

## Verification
The hardest situation to reach is a mixed bus: some lanes still hold an old host value while others carry the class code. That only happens in 16-bit mode after a full-width write. The stimulus writes a 32-bit pattern, switches the strap to 16 bits, and reads the identification word. It then releases the bus and checks that the upper half keeps the written pattern while the lower half keeps the code. The empty-bank probe needs a second build with no responder, driven with the same write-0xFF-then-read sequence.

// File: rtl/cid_pkg.sv
package cid_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] CID_RESERVED = 8'hFF;

  typedef enum logic {
    BUS_NARROW = 1'b0,
    BUS_WIDE   = 1'b1
  } bus_width_e;
endpackage

// File: rtl/cid_rst_sync.sv
module cid_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/cid_addr_decode.sv
module cid_addr_decode #(
  parameter int ADDR_W   = 26,
  parameter int DEC_BITS = 26
) (
  input  logic [ADDR_W-1:0] addr,
  input  cid_pkg::bus_width_e width,
  output logic              hit
);
  logic upper_ones;
  logic lane_ok;
  logic unused_a0;

  assign unused_a0 = addr[0];

  generate
    if (DEC_BITS > 2) begin : g_cmp
      assign upper_ones = &addr[DEC_BITS-1:2];
    end else begin : g_nocmp
      assign upper_ones = 1'b1;
    end
    if (DEC_BITS < ADDR_W) begin : g_part
      logic [ADDR_W-DEC_BITS-1:0] unused_hi;
      assign unused_hi = addr[ADDR_W-1:DEC_BITS];
    end
  endgenerate

  always_comb begin
    // wide bank ignores bit 1; narrow bank needs it set (bit 0 always ignored)
    lane_ok = (width == cid_pkg::BUS_WIDE) ? 1'b1 : addr[1];
    hit     = upper_ones & lane_ok;
  end
endmodule

// File: rtl/cid_drive.sv
module cid_drive #(
  parameter int          DATA_W     = 32,
  parameter logic [7:0]  CLASS_CODE = 8'h5A,
  parameter bit          PRESENT    = 1'b1,
  localparam int         LANES      = DATA_W / cid_pkg::BYTE_W
) (
  input  logic               cs_n,
  input  logic               oe_n,
  input  logic               hit,
  input  cid_pkg::bus_width_e width,
  output logic [LANES-1:0]   lane_en,
  output logic [DATA_W-1:0]  data
);
  logic [LANES-1:0] width_mask;

  genvar gi;
  generate
    for (gi = 0; gi < LANES; gi++) begin : g_mask
      assign width_mask[gi] = (width == cid_pkg::BUS_WIDE) || (gi < LANES / 2);
    end

    if (PRESENT) begin : g_present
      logic fire;
      always_comb begin
        fire    = !cs_n && !oe_n && hit;
        lane_en = fire ? width_mask : '0;
        data    = fire ? {{(DATA_W-cid_pkg::BYTE_W){1'b0}}, CLASS_CODE} : '0;
      end
    end else begin : g_absent
      logic unused_in;
      assign unused_in = cs_n ^ oe_n ^ hit ^ (^width_mask);
      assign lane_en   = '0;
      assign data      = '0;
    end
  endgenerate
endmodule

// File: rtl/cid_bus_keeper.sv
module cid_bus_keeper #(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / cid_pkg::BYTE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  cid_pkg::bus_width_e width,
  input  logic [LANES-1:0]   rsp_lane_en,
  input  logic [DATA_W-1:0]  rsp_data,
  input  logic               host_drive,
  input  logic [DATA_W-1:0]  host_data,
  output logic [DATA_W-1:0]  bus_level
);
  localparam int BW = cid_pkg::BYTE_W;

  genvar gi;
  generate
    for (gi = 0; gi < LANES; gi++) begin : g_lane
      logic          host_lane;
      logic          any_drv;
      logic [BW-1:0] drv_val;
      logic [BW-1:0] hold_q;

      always_comb begin
        host_lane = host_drive && ((width == cid_pkg::BUS_WIDE) || (gi < LANES / 2));
        any_drv   = rsp_lane_en[gi] || host_lane;
        drv_val   = rsp_lane_en[gi] ? rsp_data[gi*BW +: BW] : host_data[gi*BW +: BW];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       hold_q <= '0;
        else if (any_drv) hold_q <= drv_val;
      end

      assign bus_level[gi*BW +: BW] = any_drv ? drv_val : hold_q;
    end
  endgenerate
endmodule

// File: rtl/cid_responder.sv
module cid_responder #(
  parameter int         ADDR_W     = 26,
  parameter int         DATA_W     = 32,
  parameter int         DEC_BITS   = 26,
  parameter logic [7:0] CLASS_CODE = 8'h5A,
  parameter bit         PRESENT    = 1'b1,
  localparam int        LANES      = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              bus_wide,
  input  logic              host_drive,
  input  logic [DATA_W-1:0] host_data,
  output logic [LANES-1:0]  rsp_lane_en,
  output logic [DATA_W-1:0] rsp_data,
  output logic [DATA_W-1:0] bus_level
);
  cid_pkg::bus_width_e width;
  logic                hit;
  logic                rst_n_int;

  assign width = bus_wide ? cid_pkg::BUS_WIDE : cid_pkg::BUS_NARROW;

  cid_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  cid_addr_decode #(.ADDR_W(ADDR_W), .DEC_BITS(DEC_BITS)) u_dec (
    .addr  (addr),
    .width (width),
    .hit   (hit)
  );

  cid_drive #(.DATA_W(DATA_W), .CLASS_CODE(CLASS_CODE), .PRESENT(PRESENT)) u_drv (
    .cs_n    (cs_n),
    .oe_n    (oe_n),
    .hit     (hit),
    .width   (width),
    .lane_en (rsp_lane_en),
    .data    (rsp_data)
  );

  cid_bus_keeper #(.DATA_W(DATA_W)) u_keep (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .width       (width),
    .rsp_lane_en (rsp_lane_en),
    .rsp_data    (rsp_data),
    .host_drive  (host_drive),
    .host_data   (host_data),
    .bus_level   (bus_level)
  );
endmodule

// File: rtl/cid_responder_chk.sv
module cid_responder_chk #(
  parameter int         ADDR_W     = 26,
  parameter int         DATA_W     = 32,
  parameter int         DEC_BITS   = 26,
  parameter logic [7:0] CLASS_CODE = 8'h5A,
  localparam int        LANES      = DATA_W / 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              oe_n,
  input logic [ADDR_W-1:0] addr,
  input logic              bus_wide,
  input logic              host_drive,
  input logic [LANES-1:0]  rsp_lane_en,
  input logic [DATA_W-1:0] rsp_data,
  input logic [DATA_W-1:0] bus_level
);
  localparam logic [LANES-1:0] NARROW_MASK = {{(LANES - LANES/2){1'b0}}, {(LANES/2){1'b1}}};

  logic armed;
  logic lane0_drv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  assign lane0_drv = rsp_lane_en[0] || host_drive;

  // R4
  drive_needs_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|rsp_lane_en) |-> (!cs_n && !oe_n));

  // R2
  narrow_bit1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|rsp_lane_en) && !bus_wide) |-> addr[1]);

  generate
    if (DEC_BITS > 2) begin : g_r3
      // R3
      drive_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|rsp_lane_en) |-> (&addr[DEC_BITS-1:2]));
    end
  endgenerate

  // R5
  lane_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|rsp_lane_en) |-> (rsp_lane_en == (bus_wide ? {LANES{1'b1}} : NARROW_MASK)));

  // R5
  class_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|rsp_lane_en) |-> (rsp_data[7:0] == CLASS_CODE && rsp_data[DATA_W-1:8] == '0));

  // R6
  no_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|rsp_lane_en) |-> (rsp_data[7:0] != 8'hFF));

  // R7
  keeper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !lane0_drv) |-> (bus_level[7:0] == $past(bus_level[7:0])));
endmodule

bind cid_responder cid_responder_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEC_BITS(DEC_BITS), .CLASS_CODE(CLASS_CODE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n), .addr(addr),
  .bus_wide(bus_wide), .host_drive(host_drive), .rsp_lane_en(rsp_lane_en),
  .rsp_data(rsp_data), .bus_level(bus_level)
);

// File: tb/tb_cid_responder.sv
module tb_cid_responder;
  localparam logic [7:0] CLS   = 8'h5A;
  localparam logic [7:0] CLS_P = 8'hA3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cs_n, oe_n, bus_wide, host_drive;
  logic [25:0] addr;
  logic [31:0] host_data;

  logic [3:0]  en_a, en_e, en_p;
  logic [31:0] d_a, d_e, d_p, lv_a, lv_e, lv_p;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    string       tag;
    logic [3:0]  en;
    logic [31:0] data;
    logic [31:0] lvl;
  } exp_t;

  exp_t exp_q[$];
  event sample_ev;

  always #4 clk = ~clk;

  cid_responder #(.CLASS_CODE(CLS)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n), .addr(addr),
    .bus_wide(bus_wide), .host_drive(host_drive), .host_data(host_data),
    .rsp_lane_en(en_a), .rsp_data(d_a), .bus_level(lv_a));

  cid_responder #(.CLASS_CODE(CLS), .PRESENT(1'b0)) dut_empty (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n), .addr(addr),
    .bus_wide(bus_wide), .host_drive(host_drive), .host_data(host_data),
    .rsp_lane_en(en_e), .rsp_data(d_e), .bus_level(lv_e));

  cid_responder #(.CLASS_CODE(CLS_P), .DEC_BITS(12)) dut_part (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n), .addr(addr),
    .bus_wide(bus_wide), .host_drive(host_drive), .host_data(host_data),
    .rsp_lane_en(en_p), .rsp_data(d_p), .bus_level(lv_p));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic c, input logic o, input logic w,
                       input logic [25:0] a, input logic hd, input logic [31:0] hv);
    @(negedge clk);
    cs_n = c; oe_n = o; bus_wide = w; addr = a; host_drive = hd; host_data = hv;
  endtask

  task automatic idle();
    drive(1'b1, 1'b1, bus_wide, 26'h0, 1'b0, 32'h0);
  endtask

  task automatic expect_dut(input string tag, input logic [3:0] en,
                            input logic [31:0] data, input logic [31:0] lvl);
    exp_t e;
    e.tag = tag; e.en = en; e.data = data; e.lvl = lvl;
    exp_q.push_back(e);
    -> sample_ev;
    #2;
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(sample_ev);
      #1;
      while (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        chk({e.tag, " lanes"}, {28'h0, en_a}, {28'h0, e.en});
        if (e.en != 4'h0) chk({e.tag, " data"}, d_a, e.data);
        chk({e.tag, " level"}, lv_a, e.lvl);
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; oe_n = 1'b1; bus_wide = 1'b1;
    addr = '0; host_drive = 1'b0; host_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    expect_dut("R7 reset", 4'h0, 32'h0, 32'h0);
    #1 chk("R7 reset empty level", lv_e, 32'h0);

    // R1, R5: wide read, bits 1:0 ignored
    drive(1'b0, 1'b0, 1'b1, 26'h3FFFFFC, 1'b0, 32'h0);
    expect_dut("R1 R5 wide FC", 4'hF, {24'h0, CLS}, {24'h0, CLS});
    drive(1'b0, 1'b0, 1'b1, 26'h3FFFFFF, 1'b0, 32'h0);
    expect_dut("R1 wide FF", 4'hF, {24'h0, CLS}, {24'h0, CLS});
    #1 chk("R6 not reserved", {24'h0, d_a[7:0]} == 32'hFF ? 32'h1 : 32'h0, 32'h0);
    idle();
    expect_dut("R7 hold after read", 4'h0, 32'h0, {24'h0, CLS});

    // R7: host write, then hold
    drive(1'b1, 1'b1, 1'b1, 26'h0, 1'b1, 32'h12345678);
    expect_dut("R7 host drive", 4'h0, 32'h0, 32'h12345678);
    idle();
    expect_dut("R7 hold host", 4'h0, 32'h0, 32'h12345678);

    // R2, R5: narrow mode mixed bus
    drive(1'b0, 1'b0, 1'b0, 26'h3FFFFFE, 1'b0, 32'h0);
    expect_dut("R2 R5 narrow FE", 4'h3, {24'h0, CLS}, {16'h1234, 8'h00, CLS});
    drive(1'b0, 1'b0, 1'b0, 26'h3FFFFFF, 1'b0, 32'h0);
    expect_dut("R2 narrow bit0 ignored", 4'h3, {24'h0, CLS}, {16'h1234, 8'h00, CLS});
    drive(1'b0, 1'b0, 1'b0, 26'h3FFFFFC, 1'b0, 32'h0);
    expect_dut("R2 narrow bit1 clear", 4'h0, 32'h0, {16'h1234, 8'h00, CLS});
    idle();
    expect_dut("R7 mixed hold", 4'h0, 32'h0, {16'h1234, 8'h00, CLS});

    // R3: other addresses
    drive(1'b0, 1'b0, 1'b1, 26'h1FFFFFC, 1'b0, 32'h0);
    expect_dut("R3 top bit clear", 4'h0, 32'h0, {16'h1234, 8'h00, CLS});
    drive(1'b0, 1'b0, 1'b1, 26'h3FFFFF8, 1'b0, 32'h0);
    expect_dut("R3 bit2 clear", 4'h0, 32'h0, {16'h1234, 8'h00, CLS});

    // R4: partial strobes
    drive(1'b1, 1'b0, 1'b1, 26'h3FFFFFC, 1'b0, 32'h0);
    expect_dut("R4 cs high", 4'h0, 32'h0, {16'h1234, 8'h00, CLS});
    drive(1'b0, 1'b1, 1'b1, 26'h3FFFFFC, 1'b0, 32'h0);
    expect_dut("R4 oe high", 4'h0, 32'h0, {16'h1234, 8'h00, CLS});

    // R9: partial decode
    drive(1'b0, 1'b0, 1'b1, 26'h0000FFC, 1'b0, 32'h0);
    expect_dut("R9 full decode misses", 4'h0, 32'h0, {16'h1234, 8'h00, CLS});
    #1;
    chk("R9 partial lanes", {28'h0, en_p}, 32'hF);
    chk("R9 partial data", d_p, {24'h0, CLS_P});

    // R8: empty-bank probe
    drive(1'b1, 1'b1, 1'b1, 26'h0, 1'b1, 32'h000000FF);
    drive(1'b0, 1'b0, 1'b1, 26'h3FFFFFC, 1'b0, 32'h0);
    #1;
    chk("R8 empty lanes", {28'h0, en_e}, 32'h0);
    chk("R8 empty level", lv_e, 32'h000000FF);
    chk("R8 present answers", lv_a, {24'h0, CLS});
    idle();
    #1 chk("R8 empty level held", lv_e, 32'h000000FF);

    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule